// File: doc/BRIEF.md
# Protected Clock Control Register with System Clock Divider

This block holds an 8-bit clock control register and the system clock divider that the register drives. A simple bus writes the register. A write lands only while a separate unlock input is high. Some fields do not simply store what was written:

- The low-speed oscillator stop bit follows the oscillator-select input.
- The stop-all-clocks bit and the low-speed stop bit are frozen while count-source-protect mode is active.
- Entering stop mode raises the drive-strength bit by hardware.

The divider turns the input clock into a one-cycle enable pulse. The 2-bit divide code selects a ratio of 1, 2, 4 or 16. An override input replaces that ratio with a fixed default ratio. The block also derives the idle state of the oscillator output pin from the stop bit, the pin mode and an external main-clock-stop input.

Top module: `clkctl_reg`

## Requirements
- R1: After reset the register reads 0x20: drive bit (bit 5) is 1 and every other bit is 0. The divide code is 00, so `sysclk_en` pulses every cycle.
- R2: A write with `bus_we`=1 updates the register on the next clock only when `wr_unlock`=1. With `wr_unlock`=0 the register is unchanged.
- R3: Divide code in bits 7:6 gives the number of clock cycles between `sysclk_en` pulses: 00=1, 01=2, 10=4, 11=16.
- R4: While `div_override`=1 the pulse spacing is OVR_RATIO cycles (default 8), whatever the divide code.
- R5: A new divide ratio takes effect only at the next pulse. The period already in progress completes at its old length.
- R6: Low-speed stop bit (bit 4):
  - it is set to 1 in the cycle after `osc_sel_onchip` falls (main clock selected);
  - it is cleared in the cycle after `osc_sel_onchip` rises;
  - while `osc_sel_onchip`=1, writing 1 to it has no effect.
- R7: While `csp_mode`=1, written values for bit 0 and bit 4 are ignored. The other fields still take the write.
- R8: An accepted write of 1 to bit 0 (stop all clocks) sets bit 5 to 1, even if the written bit 5 is 0.
- R9: Pin outputs:
  - `pin_out_high`=1 when bit 3 (pin mode) is 1 and either bit 0 is 1 or `main_stop` is 1;
  - `pin_input_mode`=1 exactly when bit 3 is 0.
- R10: Bits 1 and 2 always read 0, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| wr_unlock | input | 1 | Write enable gate; writes are dropped when 0 |
| osc_sel_onchip | input | 1 | 1: on-chip oscillator selected, 0: main clock |
| div_override | input | 1 | 1: divider uses the fixed default ratio |
| csp_mode | input | 1 | Count-source-protect mode active |
| main_stop | input | 1 | Main clock stopped indication |
| reg_rdata | output | 8 | Current register value |
| stop_all | output | 1 | Stop-all-clocks field |
| pin_osc_mode | output | 1 | Pin mode field: 1 oscillator pins, 0 general input |
| lso_stop | output | 1 | Low-speed oscillator stop field |
| drive_high | output | 1 | Drive-strength field |
| div_sel | output | 2 | Divide code field |
| sysclk_en | output | 1 | Divided system clock enable pulse |
| pin_out_high | output | 1 | Output pin idles high |
| pin_input_mode | output | 1 | Output pin placed in input mode |

## Verification
A wrong field value shows on `reg_rdata` and the field outputs one cycle after the write or mode change that caused it. A corrupted divider count or a ratio latched at the wrong time shows as a wrong gap between `sysclk_en` pulses. That gap is visible no later than the second pulse after the change. The divider test checks the exact length of the period that straddles a ratio change, so a glitch is caught even though the average rate recovers.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int REG_W     = 8;
   localparam int B_STOP    = 0;
   localparam int B_PINOSC  = 3;
   localparam int B_LSO     = 4;
   localparam int B_DRV     = 5;
   localparam int B_DIV_LO  = 6;
   localparam int B_DIV_HI  = 7;
   localparam logic [REG_W-1:0] RESET_VAL = 8'h20;
   localparam int MAX_RATIO = 16;
   localparam int RATIO_W   = $clog2(MAX_RATIO) + 1;
   localparam int CNT_W     = $clog2(MAX_RATIO);

   function automatic logic [RATIO_W-1:0] ratio_of(input logic [1:0] code);
      case (code)
         2'b00:   ratio_of = RATIO_W'(1);
         2'b01:   ratio_of = RATIO_W'(2);
         2'b10:   ratio_of = RATIO_W'(4);
         default: ratio_of = RATIO_W'(16);
      endcase
   endfunction
endpackage

// File: rtl/clkctl_fields.sv
module clkctl_fields
   import clkctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [REG_W-1:0] bus_wdata,
   input  logic             wr_unlock,
   input  logic             osc_sel_onchip,
   input  logic             csp_mode,
   output logic             stop_q,
   output logic             pin_q,
   output logic             lso_q,
   output logic             drv_q,
   output logic [1:0]       div_q
);
   logic       wr_ok, wr_free;
   logic       osc_q;
   logic       stop_d, pin_d, lso_d, drv_d;
   logic [1:0] div_d;

   assign wr_ok   = bus_we & wr_unlock;
   assign wr_free = wr_ok & ~csp_mode;

   always_comb begin
      stop_d = stop_q;
      pin_d  = pin_q;
      drv_d  = drv_q;
      div_d  = div_q;
      lso_d  = lso_q;
      if (wr_ok) begin
         pin_d = bus_wdata[B_PINOSC];
         drv_d = bus_wdata[B_DRV];
         div_d = bus_wdata[B_DIV_HI:B_DIV_LO];
      end
      if (wr_free) begin
         stop_d = bus_wdata[B_STOP];
         if (bus_wdata[B_STOP]) drv_d = 1'b1;
      end
      if (osc_sel_onchip != osc_q)
         lso_d = ~osc_sel_onchip;
      else if (wr_free)
         lso_d = osc_sel_onchip ? 1'b0 : bus_wdata[B_LSO];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_q <= RESET_VAL[B_STOP];
         pin_q  <= RESET_VAL[B_PINOSC];
         lso_q  <= RESET_VAL[B_LSO];
         drv_q  <= RESET_VAL[B_DRV];
         div_q  <= RESET_VAL[B_DIV_HI:B_DIV_LO];
         osc_q  <= 1'b0;
      end else begin
         stop_q <= stop_d;
         pin_q  <= pin_d;
         lso_q  <= lso_d;
         drv_q  <= drv_d;
         div_q  <= div_d;
         osc_q  <= osc_sel_onchip;
      end
   end

   assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && wr_unlock) |=> $stable({div_q, pin_q}));
   assert_onchip_lso_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_sel_onchip && $past(osc_sel_onchip)) |-> !lso_q);
   assert_csp_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      csp_mode |=> $stable(stop_q));
   assert_stop_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_q) |-> drv_q);
endmodule

// File: rtl/clkctl_div.sv
module clkctl_div
   import clkctl_pkg::*;
#(
   parameter int OVR_RATIO = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] div_code,
   input  logic       div_override,
   output logic       tick
);
   localparam logic [RATIO_W-1:0] OVR_R = RATIO_W'(OVR_RATIO);

   initial begin
      assert (OVR_RATIO >= 1 && OVR_RATIO <= MAX_RATIO)
         else $error("OVR_RATIO out of range");
   end

   logic [RATIO_W-1:0] ratio_now;
   logic [CNT_W-1:0]   cnt;

   assign ratio_now = div_override ? OVR_R : ratio_of(div_code);
   assign tick      = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (tick)  cnt <= CNT_W'(ratio_now - 1'b1);
      else            cnt <= cnt - 1'b1;
   end

   assert_no_double_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ratio_now > 1) |=> !tick);
   assert_override_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div_override && OVR_RATIO > 1) |=> !tick);
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
   import clkctl_pkg::*;
#(
   parameter int OVR_RATIO = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [REG_W-1:0] bus_wdata,
   input  logic             wr_unlock,
   input  logic             osc_sel_onchip,
   input  logic             div_override,
   input  logic             csp_mode,
   input  logic             main_stop,
   output logic [REG_W-1:0] reg_rdata,
   output logic             stop_all,
   output logic             pin_osc_mode,
   output logic             lso_stop,
   output logic             drive_high,
   output logic [1:0]       div_sel,
   output logic             sysclk_en,
   output logic             pin_out_high,
   output logic             pin_input_mode
);
   clkctl_fields u_fields (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .wr_unlock(wr_unlock), .osc_sel_onchip(osc_sel_onchip), .csp_mode(csp_mode),
      .stop_q(stop_all), .pin_q(pin_osc_mode), .lso_q(lso_stop),
      .drv_q(drive_high), .div_q(div_sel)
   );

   clkctl_div #(.OVR_RATIO(OVR_RATIO)) u_div (
      .clk(clk), .rst_n(rst_n), .div_code(div_sel),
      .div_override(div_override), .tick(sysclk_en)
   );

   always_comb begin
      reg_rdata                   = '0;
      reg_rdata[B_STOP]           = stop_all;
      reg_rdata[B_PINOSC]         = pin_osc_mode;
      reg_rdata[B_LSO]            = lso_stop;
      reg_rdata[B_DRV]            = drive_high;
      reg_rdata[B_DIV_HI:B_DIV_LO] = div_sel;
   end

   assign pin_out_high   = pin_osc_mode & (stop_all | main_stop);
   assign pin_input_mode = ~pin_osc_mode;

   assert_pin_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pin_input_mode |-> !pin_out_high);
   assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && wr_unlock) |=> (reg_rdata[2:1] == 2'b00));
endmodule

// File: tb/clkctl_reg_bench.sv
module clkctl_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic       wr_unlock = 1'b0;
   logic       osc_sel_onchip = 1'b0;
   logic       div_override = 1'b0;
   logic       csp_mode = 1'b0;
   logic       main_stop = 1'b0;
   logic [7:0] reg_rdata;
   logic       stop_all, pin_osc_mode, lso_stop, drive_high, sysclk_en;
   logic       pin_out_high, pin_input_mode;
   logic [1:0] div_sel;

   always #10 clk = ~clk;

   clkctl_reg u_clkctl_reg (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .wr_unlock(wr_unlock), .osc_sel_onchip(osc_sel_onchip),
      .div_override(div_override), .csp_mode(csp_mode), .main_stop(main_stop),
      .reg_rdata(reg_rdata), .stop_all(stop_all), .pin_osc_mode(pin_osc_mode),
      .lso_stop(lso_stop), .drive_high(drive_high), .div_sel(div_sel),
      .sysclk_en(sysclk_en), .pin_out_high(pin_out_high),
      .pin_input_mode(pin_input_mode)
   );

   typedef struct {
      int    kind;
      int    idx;
      int    exp;
      string req;
   } item_t;

   item_t sb_q[$];
   int    gap_hist[int];
   int    pulse_cnt = 0;
   int    since = 0;
   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   always @(negedge clk) begin
      int act;
      if (rst_n) begin
         if (sysclk_en) begin
            pulse_cnt++;
            gap_hist[pulse_cnt] = since;
            since = 1;
         end else begin
            since++;
         end
      end
      while (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         case (it.kind)
            0:       act = int'(reg_rdata);
            1:       act = int'({pin_input_mode, pin_out_high});
            default: act = gap_hist.exists(it.idx) ? gap_hist[it.idx] : -1;
         endcase
         n_checks++;
         if (act != it.exp) begin
            n_fail++;
            $display("FAIL %s: kind %0d actual 0x%0h expected 0x%0h",
                     it.req, it.kind, act, it.exp);
         end
      end
   end

   task automatic push(input int kind, input int idx, input int exp, input string req);
      item_t it;
      it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic wr(input logic [7:0] d, input logic unl);
      @(negedge clk);
      bus_we = 1'b1; bus_wdata = d; wr_unlock = unl;
      @(posedge clk); #1;
      bus_we = 1'b0; wr_unlock = 1'b0;
   endtask

   task automatic check_period(input int exp, input string req);
      int base;
      base = pulse_cnt;
      wait (pulse_cnt >= base + 3);
      push(2, base + 3, exp, req);
   endtask

   initial begin
      int base;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset value, pin input mode, undivided enable
      push(0, 0, 8'h20, "R1");
      push(1, 0, 2'b10, "R1");
      check_period(1, "R1");
      // R2: locked write dropped
      wr(8'h08, 1'b0);
      push(0, 0, 8'h20, "R2");
      // R10 and R2: reserved bits read 0, unlocked write lands
      wr(8'h0E, 1'b1);
      push(0, 0, 8'h08, "R10");
      push(1, 0, 2'b00, "R9");
      // R9: main clock stop drives pin high
      @(negedge clk); main_stop = 1'b1; #1;
      push(1, 0, 2'b01, "R9");
      @(negedge clk); main_stop = 1'b0;
      // R8: stop write forces drive bit
      wr(8'h09, 1'b1);
      push(0, 0, 8'h29, "R8");
      push(1, 0, 2'b01, "R9");
      wr(8'h08, 1'b1);
      push(0, 0, 8'h08, "R8");
      // R6: oscillator select forcing
      wr(8'h18, 1'b1);
      push(0, 0, 8'h18, "R6");
      @(negedge clk); osc_sel_onchip = 1'b1;
      @(posedge clk); #1;
      push(0, 0, 8'h08, "R6");
      wr(8'h18, 1'b1);
      push(0, 0, 8'h08, "R6");
      @(negedge clk); osc_sel_onchip = 1'b0;
      @(posedge clk); #1;
      push(0, 0, 8'h18, "R6");
      // R7: protect mode freezes bits 0 and 4
      @(negedge clk); csp_mode = 1'b1;
      wr(8'h49, 1'b1);
      push(0, 0, 8'h58, "R7");
      @(negedge clk); csp_mode = 1'b0;
      // R3: ratio encoding
      wr(8'h48, 1'b1); check_period(2, "R3");
      wr(8'h88, 1'b1); check_period(4, "R3");
      wr(8'hC8, 1'b1); check_period(16, "R3");
      wr(8'h08, 1'b1); check_period(1, "R3");
      // R4: override ratio
      @(negedge clk); div_override = 1'b1;
      check_period(8, "R4");
      @(negedge clk); div_override = 1'b0;
      // R5: change mid-period keeps the running period intact
      wr(8'hC8, 1'b1); check_period(16, "R5");
      base = pulse_cnt;
      wait (pulse_cnt >= base + 1);
      repeat (3) @(negedge clk);
      wr(8'h08, 1'b1);
      wait (pulse_cnt >= base + 3);
      push(2, base + 2, 16, "R5");
      push(2, base + 3, 1, "R5");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule